// File: doc/BRIEF.md
# Configuration Bank Lock Guard

This block keeps a small bank of configuration registers safe from stray writes. The bank stays locked until software performs a two-write handshake: a fixed 32-bit key goes into a first kick register, and then a different fixed key goes into a second kick register. Once both keys have arrived in that order, writes to the protected registers take effect. A wrong value written to either kick register drops any partial progress and relocks the bank.

The block presents one simple register port, with a write side and a combinational read side. Software can read the bank at any time and can read a status word that reports whether the bank is open. A build-time parameter removes the lock altogether. The bank is then always open and kick writes do nothing.

Top module: `cfg_lock_guard`

## Requirements
- R1: After reset with the lock enabled, `unlocked` is 0, no key progress is held, and every protected register reads 0.
- R2: While locked, a write to a protected register (offsets 4 to 4+NUM_REGS-1) is dropped and the stored value is unchanged.
- R3: Writing 0x83E70B13 to offset 0 and then 0x95A4F1E0 to offset 1 raises `unlocked` in the cycle after the second write. Other accesses between the two writes do not cancel the handshake.
- R4: Writing 0x95A4F1E0 to offset 1 without a preceding accepted first key leaves the bank locked.
- R5: Any value other than its key written to offset 0 or offset 1 clears partial progress, so a following second key does not unlock.
- R6: While unlocked, a write to a protected register is stored and reads back from the next cycle.
- R7: While unlocked, a non-key value written to offset 0 or offset 1 relocks the bank in the next cycle. Writing the matching key to either offset keeps the bank open.
- R8: A read of offset 2 returns `unlocked` in bit 0 and zeros in the other bits. Reads of offsets 0, 1 and 3, and of offsets above the bank, return 0.
- R9: With LOCK_EN = 0, `unlocked` is always 1, protected writes always take effect, and kick writes have no effect.
- R10: Reads of protected registers return their stored contents whether the bank is locked or not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | ADDR_W | Write word offset |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read word offset |
| rd_data | output | DATA_W | Combinational read data |
| unlocked | output | 1 | High while protected writes are accepted |

## Verification
A lock state machine that has drifted is visible at `unlocked` and at the status word in the cycle after the write that caused it. A corrupted bank shows up on the next read of the affected offset. A partial-progress flag that is held too long or cleared too early stays hidden until the next second-key write, which then opens or fails to open the bank. For this reason the bench follows each kind of wrong kick value with a correct second key. A reference model compares `unlocked` and the read data on every clock, so any divergence is reported within one cycle of the write that caused it.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
   typedef enum logic [1:0] {
      LK_IDLE  = 2'd0,
      LK_ARMED = 2'd1,
      LK_OPEN  = 2'd2
   } lock_state_e;

   localparam int KICK_A_OFS = 0;
   localparam int KICK_B_OFS = 1;
   localparam int STATUS_OFS = 2;
   localparam int BANK_OFS   = 4;
endpackage

// File: rtl/cfg_lock_seq.sv
module cfg_lock_seq
   import cfg_lock_pkg::*;
#(
   parameter int                DATA_W  = 32,
   parameter bit                LOCK_EN = 1'b1,
   parameter logic [DATA_W-1:0] KEY_A   = DATA_W'(32'h83E70B13),
   parameter logic [DATA_W-1:0] KEY_B   = DATA_W'(32'h95A4F1E0)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kick_a_wr,
   input  logic              kick_b_wr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              unlocked,
   output logic              armed
);
   generate
      if (LOCK_EN) begin : g_lock
         lock_state_e st_q, st_d;

         always_comb begin
            st_d = st_q;
            if (kick_a_wr) begin
               if (wr_data == KEY_A)
                  st_d = (st_q == LK_OPEN) ? LK_OPEN : LK_ARMED;
               else
                  st_d = LK_IDLE;
            end else if (kick_b_wr) begin
               if (wr_data == KEY_B)
                  st_d = (st_q == LK_IDLE) ? LK_IDLE : LK_OPEN;
               else
                  st_d = LK_IDLE;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= LK_IDLE;
            else        st_q <= st_d;
         end

         assign unlocked = (st_q == LK_OPEN);
         assign armed    = (st_q == LK_ARMED);
      end else begin : g_open
         assign unlocked = 1'b1;
         assign armed    = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 4,
   localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [IDX_W-1:0]           idx,
   input  logic [DATA_W-1:0]          wdata,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         logic [DATA_W-1:0] val_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               val_q <= '0;
            else if (we && idx == IDX_W'(i))
               val_q <= wdata;
         end
         assign regs_flat[i*DATA_W +: DATA_W] = val_q;
      end
   endgenerate
endmodule

// File: rtl/cfg_lock_guard.sv
module cfg_lock_guard
   import cfg_lock_pkg::*;
#(
   parameter int                ADDR_W   = 4,
   parameter int                DATA_W   = 32,
   parameter int                NUM_REGS = 4,
   parameter bit                LOCK_EN  = 1'b1,
   parameter logic [DATA_W-1:0] KEY_A    = DATA_W'(32'h83E70B13),
   parameter logic [DATA_W-1:0] KEY_B    = DATA_W'(32'h95A4F1E0)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              unlocked
);
   localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
   localparam int BANK_END = BANK_OFS + NUM_REGS;

   generate
      if (NUM_REGS < 1 || BANK_END > (1 << ADDR_W)) begin : g_bad_map
         $error("cfg_lock_guard: bank does not fit in the address space");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("cfg_lock_guard: DATA_W too small");
      end
   endgenerate

   logic                       armed_w;
   logic                       kick_a_wr, kick_b_wr;
   logic                       wr_in_bank, rd_in_bank;
   logic [IDX_W-1:0]           wr_idx, rd_idx;
   logic [NUM_REGS*DATA_W-1:0] regs_flat;

   assign kick_a_wr  = wr_en && (wr_addr == ADDR_W'(KICK_A_OFS));
   assign kick_b_wr  = wr_en && (wr_addr == ADDR_W'(KICK_B_OFS));
   assign wr_in_bank = (int'(wr_addr) >= BANK_OFS) && (int'(wr_addr) < BANK_END);
   assign rd_in_bank = (int'(rd_addr) >= BANK_OFS) && (int'(rd_addr) < BANK_END);
   assign wr_idx     = IDX_W'(wr_addr - ADDR_W'(BANK_OFS));
   assign rd_idx     = IDX_W'(rd_addr - ADDR_W'(BANK_OFS));

   cfg_lock_seq #(
      .DATA_W (DATA_W),
      .LOCK_EN(LOCK_EN),
      .KEY_A  (KEY_A),
      .KEY_B  (KEY_B)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .kick_a_wr(kick_a_wr),
      .kick_b_wr(kick_b_wr),
      .wr_data  (wr_data),
      .unlocked (unlocked),
      .armed    (armed_w)
   );

   cfg_lock_bank #(
      .DATA_W  (DATA_W),
      .NUM_REGS(NUM_REGS)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (wr_en && wr_in_bank && unlocked),
      .idx      (wr_idx),
      .wdata    (wr_data),
      .regs_flat(regs_flat)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(STATUS_OFS))
         rd_data[0] = unlocked;
      else if (rd_in_bank)
         rd_data = regs_flat[rd_idx*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/cfg_lock_guard_chk.sv
module cfg_lock_guard_chk #(
   parameter int                ADDR_W   = 4,
   parameter int                DATA_W   = 32,
   parameter int                NUM_REGS = 4,
   parameter bit                LOCK_EN  = 1'b1,
   parameter logic [DATA_W-1:0] KEY_A    = DATA_W'(32'h83E70B13),
   parameter logic [DATA_W-1:0] KEY_B    = DATA_W'(32'h95A4F1E0)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [ADDR_W-1:0]          wr_addr,
   input logic [DATA_W-1:0]          wr_data,
   input logic                       unlocked,
   input logic                       armed,
   input logic [NUM_REGS*DATA_W-1:0] regs_flat
);
   // R2
   locked_bank_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(regs_flat));

   // R3
   open_needs_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (LOCK_EN && $rose(unlocked)) |->
         $past(wr_en && wr_addr == ADDR_W'(1) && wr_data == KEY_B));

   // R4
   lone_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (LOCK_EN && wr_en && wr_addr == ADDR_W'(1) && wr_data == KEY_B && !armed && !unlocked)
         |=> !unlocked);

   // R5
   bad_kick_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (LOCK_EN && wr_en && ((wr_addr == ADDR_W'(0) && wr_data != KEY_A) ||
                            (wr_addr == ADDR_W'(1) && wr_data != KEY_B)))
         |=> (!unlocked && !armed));

   // R7
   first_key_keeps_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && wr_en && wr_addr == ADDR_W'(0) && wr_data == KEY_A) |=> unlocked);

   // R9
   bypass_always_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !LOCK_EN |-> unlocked);
endmodule

bind cfg_lock_guard cfg_lock_guard_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .NUM_REGS(NUM_REGS),
   .LOCK_EN (LOCK_EN),
   .KEY_A   (KEY_A),
   .KEY_B   (KEY_B)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .unlocked (unlocked),
   .armed    (armed_w),
   .regs_flat(regs_flat)
);

// File: tb/test_cfg_lock_guard.sv
`timescale 1ns/1ps
module test_cfg_lock_guard;
   localparam int AW = 4;
   localparam int DW = 32;
   localparam int NR = 4;
   localparam logic [31:0] KA = 32'h83E70B13;
   localparam logic [31:0] KB = 32'h95A4F1E0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] lk_rd, op_rd;
   logic          lk_unl, op_unl;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string phase = "R1";

   always #4 clk = ~clk;

   cfg_lock_guard #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR), .LOCK_EN(1'b1)) i_cfg_lock_guard (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(lk_rd), .unlocked(lk_unl));

   cfg_lock_guard #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR), .LOCK_EN(1'b0)) i_cfg_lock_guard_open (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(op_rd), .unlocked(op_unl));

   // Behavioural reference: 0 = no progress, 1 = first key seen, 2 = open
   int            m_state;
   logic [DW-1:0] m_regs [NR];
   logic [DW-1:0] o_regs [NR];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0;
         for (int i = 0; i < NR; i++) begin
            m_regs[i] = '0;
            o_regs[i] = '0;
         end
      end else if (wr_en) begin
         if (wr_addr == 0) begin
            if (wr_data == KA) m_state = (m_state == 2) ? 2 : 1;
            else               m_state = 0;
         end else if (wr_addr == 1) begin
            if (wr_data == KB) m_state = (m_state == 0) ? 0 : 2;
            else               m_state = 0;
         end else if (wr_addr >= 4 && wr_addr < 4 + NR) begin
            if (m_state == 2) m_regs[wr_addr-4] = wr_data;
            o_regs[wr_addr-4] = wr_data;
         end
      end
   end

   function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a, input bit open_inst);
      logic [DW-1:0] v = '0;
      if (a == 2) v[0] = open_inst ? 1'b1 : (m_state == 2);
      else if (a >= 4 && a < 4 + NR) v = open_inst ? o_regs[a-4] : m_regs[a-4];
      return v;
   endfunction

   task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", phase, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(DW'(lk_unl), DW'(m_state == 2), "locked unit unlocked flag");
         check(lk_rd, model_rd(rd_addr, 1'b0), "locked unit read data");
         // R9
         check(DW'(op_unl), DW'(1), "bypass unit unlocked flag");
         check(op_rd, model_rd(rd_addr, 1'b1), "bypass unit read data");
      end
   end

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(posedge clk); #2;
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic rd_expect(input int a, input logic [DW-1:0] exp_lk, input logic [DW-1:0] exp_op);
      rd_addr = AW'(a);
      @(negedge clk); #1;
      check(lk_rd, exp_lk, $sformatf("read of offset %0d", a));
      check(op_rd, exp_op, $sformatf("bypass read of offset %0d", a));
   endtask

   task automatic unl_expect(input logic exp);
      @(negedge clk); #1;
      check(DW'(lk_unl), DW'(exp), "unlocked output");
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      phase = "R1";
      unl_expect(1'b0);
      for (int i = 0; i < NR; i++) rd_expect(4 + i, '0, '0);

      phase = "R2";
      wr(4, 32'hAAAA_5555);
      wr(7, 32'h1234_5678);
      rd_expect(4, '0, 32'hAAAA_5555);
      rd_expect(7, '0, 32'h1234_5678);

      phase = "R4";
      wr(1, KB);
      unl_expect(1'b0);
      wr(6, 32'hDEAD_0001);
      rd_expect(6, '0, 32'hDEAD_0001);

      phase = "R5";
      wr(0, KA); wr(1, 32'h0); wr(1, KB);
      unl_expect(1'b0);
      wr(0, KA); wr(0, KA ^ 32'h1); wr(1, KB);
      unl_expect(1'b0);

      phase = "R3";
      wr(0, KA);
      unl_expect(1'b0);
      rd_addr = AW'(5);
      @(posedge clk); #2;
      wr(1, KB);
      unl_expect(1'b1);

      phase = "R8";
      rd_expect(2, 32'h1, 32'h1);
      rd_expect(0, '0, '0);
      rd_expect(1, '0, '0);
      rd_expect(3, '0, '0);
      rd_expect(8, '0, '0);

      phase = "R6";
      for (int i = 0; i < NR; i++) wr(4 + i, 32'hC0DE_0000 + DW'(i));
      for (int i = 0; i < NR; i++) rd_expect(4 + i, 32'hC0DE_0000 + DW'(i), 32'hC0DE_0000 + DW'(i));

      phase = "R7";
      wr(0, KA);
      unl_expect(1'b1);
      wr(1, KB);
      unl_expect(1'b1);
      wr(0, 32'h0);
      unl_expect(1'b0);
      wr(5, 32'hBAD0_BAD0);
      rd_expect(5, 32'hC0DE_0001, 32'hBAD0_BAD0);
      wr(0, KA); wr(1, KB);
      unl_expect(1'b1);
      wr(1, KA);
      unl_expect(1'b0);
      rd_expect(2, 32'h0, 32'h1);

      phase = "R10";
      rd_expect(4, 32'hC0DE_0000, 32'hC0DE_0000);
      rd_expect(7, 32'hC0DE_0003, 32'hC0DE_0003);

      phase = "R9";
      wr(6, 32'h0F0F_F0F0);
      rd_expect(6, 32'hC0DE_0002, 32'h0F0F_F0F0);
      @(negedge clk); #1;
      check(DW'(op_unl), DW'(1), "bypass unlocked after kick writes");

      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule